// File: doc/BRIEF.md
# Clear-on-Read Fault Interrupt Collector

This block collects event and fault flags from a set of monitor circuits and turns them into one active-low interrupt request for a host. Each raw flag passes through a two-stage synchronizer. A per-bit parameter chooses whether the flag is captured on its rising transition (edge mode) or whenever it is asserted (level mode). Captured flags stay in a sticky status register until the host reads it. A mask register decides which status bits may pull the request line low. Masked bits are still captured, so the host can poll them.

Reading the status register returns its contents and clears them in the same cycle, which releases the request line. When a level-mode fault is still present after that read, a hold timer stops it from re-latching for a fixed window. The window is set by parameters as a time in microseconds multiplied by the clock rate. When the window ends, the fault is sampled again and pulls the line low once more. The pin is modelled as open drain: an output enable plus a data value that is always zero.

Top module: `fault_irq_agg`

## Requirements
- R1: A raw flag that rises while its status bit is clear sets that bit at the third rising clock edge after it is applied. The bit then stays set until a status read.
- R2: An edge-mode bit (its bit in EDGE_MODE is 1) is captured only on a low-to-high change of the synchronized flag. A flag held high does not set the bit again after a clearing read.
- R3: A level-mode bit (its bit in EDGE_MODE is 0) whose flag stays active across a clearing read stays clear for HOLD_CYC edges after the clearing edge. It is set again at edge HOLD_CYC+1, where HOLD_CYC = CLK_MHZ*HOLD_US.
- R4: A read with reg_sel_i = 0 returns the current status on rd_data_o and clears every status bit at that edge. The exception is an edge-mode bit whose capture falls on that same edge; it stays set.
- R5: A write with reg_sel_i = 1 loads the mask at that edge. A read with reg_sel_i = 1 returns the mask and leaves the status unchanged.
- R6: A masked bit is still captured into the status register.
- R7: irq_oe_o is 1 exactly when some status bit is set and its mask bit is 0. irq_od_o is always 0.
- R8: After reset the status is 0, the mask is 0 and irq_oe_o is 0.
- R9: A level-mode flag that goes inactive during the hold window leaves its bit clear after the window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | N_SRC | Raw event/fault flags, asynchronous |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe (mask only) |
| reg_sel_i | input | 1 | 0 = status register, 1 = mask register |
| wr_data_i | input | N_SRC | Mask write data |
| rd_data_o | output | N_SRC | Read data for the selected register |
| irq_oe_o | output | 1 | Pin output enable; 1 pulls the line low |
| irq_od_o | output | 1 | Pin data value, constant 0 |

## Verification
A new edge-mode capture can land on the same clock edge as a clearing status read. In that case the capture must win and every other bit must clear. The bench provokes this by raising a flag exactly two edges before a read strobe while another bit is already latched. It then checks, through a later status read, that only the new bit survived. A second collision is between the hold window and a level fault that is still active. There the bench follows irq_oe_o edge by edge and checks that it comes back exactly at edge HOLD_CYC+1, and stays low when the flag has dropped.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] async_i,
    output logic [N_SRC-1:0] sync_o
);
    typedef struct packed {
        logic [N_SRC-1:0] meta;
        logic [N_SRC-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/irqagg_detect.sv
module irqagg_detect #(
    parameter int               N_SRC     = 8,
    parameter logic [N_SRC-1:0] EDGE_MODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] sync_i,
    input  logic             lvl_block_i,
    output logic [N_SRC-1:0] edge_evt_o,
    output logic [N_SRC-1:0] set_o
);
    typedef struct packed {
        logic [N_SRC-1:0] prev;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar b = 0; b < N_SRC; b++) begin : g_bit
        if (EDGE_MODE[b]) begin : g_edge
            assign edge_evt_o[b] = sync_i[b] & ~st_q.prev[b];
            assign set_o[b]      = edge_evt_o[b];
        end else begin : g_level
            assign edge_evt_o[b] = 1'b0;
            assign set_o[b]      = sync_i[b] & ~lvl_block_i;
        end
    end
endmodule

// File: rtl/irqagg_timer.sv
module irqagg_timer #(
    parameter int HOLD_CYC = 3200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i)
            st_d.cnt = CW'(HOLD_CYC);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.cnt != '0);

    p_timer_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(HOLD_CYC));

    p_timer_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);
endmodule

// File: rtl/fault_irq_agg.sv
module fault_irq_agg #(
    parameter int               N_SRC     = 8,
    parameter logic [N_SRC-1:0] EDGE_MODE = '0,
    parameter int               CLK_MHZ   = 100,
    parameter int               HOLD_US   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] fault_i,
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic             reg_sel_i,
    input  logic [N_SRC-1:0] wr_data_i,
    output logic [N_SRC-1:0] rd_data_o,
    output logic             irq_oe_o,
    output logic             irq_od_o
);
    import irqagg_pkg::*;

    localparam int               HOLD_CYC = CLK_MHZ * HOLD_US;
    localparam logic [N_SRC-1:0] LVL_BITS = ~EDGE_MODE;

    typedef struct packed {
        logic [N_SRC-1:0] status;
        logic [N_SRC-1:0] mask;
    } agg_st_t;

    agg_st_t st_d, st_q;

    reg_sel_e         sel;
    logic             clr;
    logic             hold_busy;
    logic [N_SRC-1:0] sync_flags;
    logic [N_SRC-1:0] edge_evt;
    logic [N_SRC-1:0] set_vec;

    assign sel = reg_sel_e'(reg_sel_i);
    assign clr = rd_en_i && (sel == SEL_STATUS);

    irqagg_sync #(.N_SRC(N_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (fault_i),
        .sync_o  (sync_flags)
    );

    irqagg_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (clr),
        .busy_o (hold_busy)
    );

    irqagg_detect #(.N_SRC(N_SRC), .EDGE_MODE(EDGE_MODE)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_flags),
        .lvl_block_i (hold_busy | clr),
        .edge_evt_o  (edge_evt),
        .set_o       (set_vec)
    );

    always_comb begin
        st_d = st_q;
        // a new capture outranks the clear on the same edge
        st_d.status = (clr ? '0 : st_q.status) | set_vec;
        if (wr_en_i && sel == SEL_MASK)
            st_d.mask = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = (sel == SEL_MASK) ? st_q.mask : st_q.status;
    assign irq_oe_o  = |(st_q.status & ~st_q.mask);
    assign irq_od_o  = 1'b0;

    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((st_q.status & $past(st_q.status)) == $past(st_q.status)));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((st_q.status & ~$past(edge_evt)) == '0));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_busy |=> ((st_q.status & ~$past(st_q.status) & LVL_BITS) == '0));

    p_mask_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel == SEL_MASK) |=> (st_q.mask == $past(wr_data_i)));

    p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && sel == SEL_MASK) |=> $stable(st_q.mask));

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && edge_evt == '0) |=> !irq_oe_o);

    p_od_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_od_o == 1'b0);
endmodule

// File: tb/fault_irq_agg_tb.sv
`timescale 1ns/1ps
module fault_irq_agg_tb;
    localparam int         N    = 4;
    localparam logic [3:0] EDGE = 4'b0011;
    localparam int         HOLD = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] fault = '0;
    logic         rd_en = 1'b0;
    logic         wr_en = 1'b0;
    logic         sel = 1'b0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         oe;
    logic         od;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fault_irq_agg #(.N_SRC(N), .EDGE_MODE(EDGE), .CLK_MHZ(1), .HOLD_US(HOLD)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_i   (fault),
        .rd_en_i   (rd_en),
        .wr_en_i   (wr_en),
        .reg_sel_i (sel),
        .wr_data_i (wdata),
        .rd_data_o (rdata),
        .irq_oe_o  (oe),
        .irq_od_o  (od)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic s, output logic [N-1:0] d);
        rd_en = 1'b1; sel = s;
        #1 d = rdata;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; sel = 1'b0;
    endtask

    task automatic do_wmask(input logic [N-1:0] m);
        wr_en = 1'b1; sel = 1'b1; wdata = m;
        @(negedge clk);
        wr_en = 1'b0; sel = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d;
        bit ok;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R8 reset state
        chk(oe == 1'b0, "R8 oe", oe, 0);
        do_read(1'b1, d);
        chk(d == '0, "R8 mask", d, 0);
        do_read(1'b0, d);
        chk(d == '0, "R8 status", d, 0);

        // R1 latency on an edge-mode bit, R7 pin
        fault[0] = 1'b1;
        tick(2);
        chk(oe == 1'b0, "R1 not yet at edge 2", oe, 0);
        tick(1);
        chk(oe == 1'b1, "R1 set at edge 3", oe, 1);
        chk(od == 1'b0, "R7 od zero", od, 0);
        tick(5);
        chk(oe == 1'b1, "R1 sticky", oe, 1);

        // R4 read returns and clears; R2 held edge flag does not re-latch
        do_read(1'b0, d);
        chk(d == 4'b0001, "R4 read value", d, 1);
        chk(oe == 1'b0, "R4 cleared", oe, 0);
        tick(HOLD + 10);
        chk(oe == 1'b0, "R2 no relatch held edge", oe, 0);
        do_read(1'b0, d);
        chk(d == '0, "R2 status empty", d, 0);
        fault[0] = 1'b0;
        tick(HOLD + 4);

        // R3 level relatch timing
        fault[2] = 1'b1;
        tick(4);
        do_read(1'b0, d);
        chk(d == 4'b0100, "R3 level captured", d, 4);
        ok = 1;
        for (int i = 1; i <= HOLD; i++) begin
            if (oe != 1'b0) ok = 0;
            tick(1);
        end
        chk(ok && oe == 1'b0, "R3 quiet through window", oe, 0);
        tick(1);
        chk(oe == 1'b1, "R3 relatched at HOLD+1", oe, 1);

        // R9 flag drops during window
        do_read(1'b0, d);
        fault[2] = 1'b0;
        tick(HOLD + 10);
        chk(oe == 1'b0, "R9 stays clear", oe, 0);
        do_read(1'b0, d);
        chk(d == '0, "R9 status empty", d, 0);
        tick(HOLD + 4);

        // R5/R6/R7 mask behaviour
        do_wmask(4'b0010);
        fault[1] = 1'b1;
        tick(4);
        chk(oe == 1'b0, "R7 masked no irq", oe, 0);
        do_read(1'b1, d);
        chk(d == 4'b0010, "R5 mask readback", d, 2);
        do_wmask(4'b0000);
        chk(oe == 1'b1, "R5 mask read kept status", oe, 1);
        do_read(1'b0, d);
        chk(d == 4'b0010, "R6 masked bit latched", d, 2);
        fault[1] = 1'b0;
        tick(HOLD + 4);

        // R4 collision: capture on the clearing edge wins
        fault[1] = 1'b1;
        tick(4);
        fault[0] = 1'b1;
        tick(2);
        do_read(1'b0, d);
        chk(d == 4'b0010, "R4 pre-collision value", d, 2);
        tick(HOLD + 4);
        do_read(1'b0, d);
        chk(d == 4'b0001, "R4 capture beats clear", d, 1);
        fault = '0;
        tick(HOLD + 4);

        // exhaustive bit x mask sweep: R1 R6 R7
        for (int b = 0; b < N; b++) begin
            for (int m = 0; m < 16; m++) begin
                logic [N-1:0] mm;
                mm = m[N-1:0];
                do_wmask(mm);
                fault[b] = 1'b1;
                tick(3);
                chk(oe == !mm[b], "R7 sweep oe", oe, !mm[b]);
                fault[b] = 1'b0;
                tick(3);
                do_read(1'b0, d);
                chk(d == (4'b1 << b), "R6 sweep status", d, 1 << b);
                tick(HOLD + 2);
            end
        end
        do_wmask('0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule